// File: doc/BRIEF.md
# ADC Conversion-Start and Power-Mode Sequencer

This block is the digital timing core of a sampling converter that is driven from a single start pin. A rising edge on the start pin launches a fixed-length internal pulse. The pin and that pulse are ORed into a gated start signal. A falling edge of the gated signal puts the sampler into hold and begins a conversion. The conversion therefore begins at whichever falling edge comes later, the pulse's or the pin's.

The analog sampler, the comparator and the successive-approximation datapath are not modelled. A conversion-time counter stands in for them, and the result is taken from a stub input. When the busy flag drops, that input is latched into an output register, which stays readable in every state.

The level of the pin at the end of a conversion selects the power mode. If the pin is high, the block stays powered for fast back-to-back conversions. If the pin is low, the block enters power-down, and the next rising edge on the pin wakes it.

Top module: `adc_start_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to its idle state: `busy`, `powered_down`, `latch_strobe`, `hold_trig` and `gated_start` are 0 and `data_out` is 0.
- R2: `start_in` passes through a two-flop synchroniser. A rising edge of the synchronised level while `busy` is low launches an internal pulse that lasts PULSE_CYCLES clocks. `gated_start` is the OR of the synchronised level and that pulse.
- R3: A falling edge of `gated_start` while `busy` is low raises `hold_trig` for exactly that one cycle, and `busy` rises on the next clock edge. When `start_in` rises just after edge 0 and falls just after edge H, `busy` is first high after edge max(PULSE_CYCLES+3, H+2)+1.
- R4: `busy` stays high for exactly CONV_CYCLES clock cycles per conversion.
- R5: In the first cycle after `busy` falls, `latch_strobe` is 1 for that one cycle and `data_out` holds the `conv_result` value sampled in the last busy cycle. `data_out` does not change at any other time.
- R6: If the synchronised `start_in` is high in the last busy cycle, `powered_down` stays 0 after the conversion.
- R7: If the synchronised `start_in` is low in the last busy cycle, `powered_down` becomes 1 in the cycle in which `busy` falls. It is never 1 while `busy` is 1.
- R8: While the block is powered down, a rising edge on `start_in` clears `powered_down` three clock edges after the pin rises.
- R9: A rising edge of the synchronised `start_in` seen while `busy` is high launches no internal pulse. A later falling edge of the pin while idle starts a conversion three edges after the pin falls.
- R10: `data_out` keeps its latched value, and stays readable, for as long as `powered_down` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_in | input | 1 | Asynchronous conversion-start pin |
| conv_result | input | DATA_W | Stub conversion result, latched at end of conversion |
| gated_start | output | 1 | OR of the synchronised pin and the internal pulse |
| hold_trig | output | 1 | One-cycle strobe: sampler enters hold, conversion begins |
| busy | output | 1 | High while a conversion is in progress |
| powered_down | output | 1 | High for the whole time the block is powered down |
| latch_strobe | output | 1 | One-cycle strobe when the result register loads |
| data_out | output | DATA_W | Output result register |

## Verification
A pulse counter that is off by one moves the rising edge of `busy` by one cycle when the pin pulse is short. The bench sweeps the pin-high time across the length of the internal pulse to catch this. A wrong mode decision or a wrong wake-up shows on `powered_down` within three cycles of the fall of `busy` or of the pin's rising edge. A pulse launched by a rise during `busy` shows only in the next conversion, as a start that comes several cycles late. A latch that loads at the wrong time shows on `data_out` once `conv_result` is changed while the block is powered down.

// File: rtl/adc_seq_pkg.sv
// Package: shared defaults and helper for the start sequencer.
// Assumes: nothing beyond IEEE 1800-2017 elaboration.
package adc_seq_pkg;

    localparam int unsigned SEQ_DATA_W      = 8;
    localparam int unsigned SEQ_PULSE_CYCLES = 6;
    localparam int unsigned SEQ_CONV_CYCLES  = 10;

    // Width of a down-counter that must hold the value n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/seq_input_sync.sv
// Module: seq_input_sync
// Brings the asynchronous start pin into the clock domain through two
// flops, then registers it once more to detect a rising edge.
// Assumes: the pin holds each level for at least two clock periods.
module seq_input_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o,
    output logic rise_o
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-stage synchroniser plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level_o = sync_q;
    assign rise_o  = sync_q & ~prev_q;

endmodule

// File: rtl/seq_start_pulse.sv
// Module: seq_start_pulse
// Fixed-length pulse generator: a trigger loads a down-counter, and the
// pulse is high while the counter is non-zero.
// Assumes: PULSE_CYCLES >= 1. A new trigger restarts the pulse.
module seq_start_pulse #(
    parameter int unsigned PULSE_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic pulse_o
);

    localparam int unsigned CW = adc_seq_pkg::cnt_width(PULSE_CYCLES);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

    logic [CW-1:0] remain_q;

    // Load on trigger, otherwise count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (trigger) begin
            remain_q <= LOAD;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign pulse_o = (remain_q != '0);

endmodule

// File: rtl/seq_conv_timer.sv
// Module: seq_conv_timer
// Stands in for the successive-approximation datapath. It holds the busy
// flag for CONV_CYCLES clocks after a start and flags the last busy cycle.
// Assumes: CONV_CYCLES >= 1. A start while busy is ignored.
module seq_conv_timer #(
    parameter int unsigned CONV_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy_o,
    output logic last_o
);

    localparam int unsigned CW = adc_seq_pkg::cnt_width(CONV_CYCLES);
    localparam logic [CW-1:0] LOAD = CW'(CONV_CYCLES - 1);

    logic          busy_q;
    logic [CW-1:0] left_q;

    // Conversion length counter with busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            left_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                left_q <= LOAD;
            end
        end else if (left_q == '0) begin
            busy_q <= 1'b0;
        end else begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign last_o = busy_q && (left_q == '0);

endmodule

// File: rtl/adc_start_sequencer.sv
// Module: adc_start_sequencer (top)
// Conversion-start and power-mode sequencer. The synchronised start pin is
// ORed with a fixed internal pulse. The falling edge of that OR starts a
// conversion. At the end of a conversion the result is latched and the pin
// level picks between staying powered and powering down.
// Assumes: start_in is asynchronous and slow compared with clk.
module adc_start_sequencer #(
    parameter int unsigned DATA_W       = adc_seq_pkg::SEQ_DATA_W,
    parameter int unsigned PULSE_CYCLES = adc_seq_pkg::SEQ_PULSE_CYCLES,
    parameter int unsigned CONV_CYCLES  = adc_seq_pkg::SEQ_CONV_CYCLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_in,
    input  logic [DATA_W-1:0] conv_result,
    output logic              gated_start,
    output logic              hold_trig,
    output logic              busy,
    output logic              powered_down,
    output logic              latch_strobe,
    output logic [DATA_W-1:0] data_out
);

    logic              ext_lvl;
    logic              ext_rise;
    logic              pulse_fire;
    logic              int_pulse;
    logic              gate_q;
    logic              conv_start;
    logic              conv_last;
    logic              pd_q;
    logic              strobe_q;
    logic [DATA_W-1:0] result_q;

    seq_input_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (start_in),
        .level_o  (ext_lvl),
        .rise_o   (ext_rise)
    );

    // A rising pin edge launches the pulse only while idle.
    assign pulse_fire = ext_rise & ~busy;

    seq_start_pulse #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (pulse_fire),
        .pulse_o (int_pulse)
    );

    assign gated_start = ext_lvl | int_pulse;

    // Delayed copy of the gated start for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= gated_start;
        end
    end

    assign conv_start = gate_q & ~gated_start & ~busy;
    assign hold_trig  = conv_start;

    seq_conv_timer #(
        .CONV_CYCLES (CONV_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (conv_start),
        .busy_o (busy),
        .last_o (conv_last)
    );

    // Power mode: decided at end of conversion, woken by a pin rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q <= 1'b0;
        end else if (pulse_fire) begin
            pd_q <= 1'b0;
        end else if (conv_last) begin
            pd_q <= ~ext_lvl;
        end
    end

    // Output register and its one-cycle load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= conv_last;
            if (conv_last) begin
                result_q <= conv_result;
            end
        end
    end

    assign powered_down = pd_q;
    assign latch_strobe = strobe_q;
    assign data_out     = result_q;

endmodule

// File: rtl/adc_start_sequencer_chk.sv
// Module: adc_start_sequencer_chk
// Checker bound into the sequencer top. It relates the port signals over
// time and counts the length of each busy interval.
// Assumes: reset is held low for at least one clock edge at start-up.
module adc_start_sequencer_chk #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CONV_CYCLES = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_lvl,
    input logic [DATA_W-1:0] conv_result,
    input logic              hold_trig,
    input logic              busy,
    input logic              powered_down,
    input logic              latch_strobe,
    input logic [DATA_W-1:0] data_out
);

    localparam int unsigned RW = $clog2(CONV_CYCLES + 2);

    logic [RW-1:0] run_len;

    // Counts the busy cycles in the current or most recent interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    AST_HOLD_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) hold_trig |=> busy); // R3
    AST_NO_HOLD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !hold_trig); // R3
    AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (run_len < RW'(CONV_CYCLES))); // R4
    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (run_len == RW'(CONV_CYCLES))); // R4
    AST_STROBE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> latch_strobe); // R5
    AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) latch_strobe |-> !busy); // R5
    AST_LATCH_VALUE: assert property (@(posedge clk) disable iff (!rst_n) latch_strobe |-> (data_out == $past(conv_result))); // R5
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !latch_strobe |-> $stable(data_out)); // R10
    AST_PD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) powered_down |-> !busy); // R7
    AST_PD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(powered_down) |-> $fell(busy)); // R7
    AST_PD_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(powered_down) |-> !$past(ext_lvl)); // R7

endmodule

bind adc_start_sequencer adc_start_sequencer_chk #(
    .DATA_W      (DATA_W),
    .CONV_CYCLES (CONV_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_lvl      (ext_lvl),
    .conv_result  (conv_result),
    .hold_trig    (hold_trig),
    .busy         (busy),
    .powered_down (powered_down),
    .latch_strobe (latch_strobe),
    .data_out     (data_out)
);

// File: tb/adc_start_sequencer_bench.sv
// Bench: sweeps the pin-high time around the internal pulse length, then
// runs a fast-mode sequence with a pin rise during busy.
module adc_start_sequencer_bench;

    localparam int  P      = 6;
    localparam int  C      = 10;
    localparam int  W      = 8;
    localparam time CLK_PD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_in = 1'b0;
    logic [W-1:0] conv_result = '0;
    logic         gated_start;
    logic         hold_trig;
    logic         busy;
    logic         powered_down;
    logic         latch_strobe;
    logic [W-1:0] data_out;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #(CLK_PD / 2) clk = ~clk;

    adc_start_sequencer #(
        .DATA_W       (W),
        .PULSE_CYCLES (P),
        .CONV_CYCLES  (C)
    ) u_adc_start_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_in     (start_in),
        .conv_result  (conv_result),
        .gated_start  (gated_start),
        .hold_trig    (hold_trig),
        .busy         (busy),
        .powered_down (powered_down),
        .latch_strobe (latch_strobe),
        .data_out     (data_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Counts busy-high negedges after the first one; returns the length.
    task automatic measure_busy(output int len);
        len = 1;
        forever begin
            @(negedge clk);
            if (!busy) break;
            len++;
            if (len > 4 * C) break;
        end
    endtask

    initial begin
        int m_exp;
        int n;
        int len;
        bit g_hi;
        bit g_lo;
        bit hold_seen;
        bit pd_before;
        bit pd_at2;
        bit pd_at3;
        logic [W-1:0] val;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!busy && !powered_down && !latch_strobe && !hold_trig && !gated_start,
              "R1 idle flags", {busy, powered_down, latch_strobe, hold_trig, gated_start}, 0);
        check(data_out == 0, "R1 data_out", data_out, 0);
        rst_n = 1'b1;

        // Power-down mode sweep over pin-high time H.
        for (int h = 1; h <= P + 5; h++) begin
            repeat (4) @(negedge clk);
            val = W'(h * 37 + 5);
            conv_result = val;
            pd_before = powered_down;
            m_exp = (P + 2 > h + 1) ? P + 2 : h + 1;
            g_hi = 0; g_lo = 0; hold_seen = 0; pd_at2 = 0; pd_at3 = 0;
            @(posedge clk);
            #1 start_in = 1'b1;
            n = 0;
            forever begin
                @(negedge clk);
                if (n == m_exp) g_hi = gated_start;
                if (n == m_exp + 1) begin
                    g_lo = !gated_start;
                    hold_seen = hold_trig;
                end
                if (n == 2) pd_at2 = powered_down;
                if (n == 3) pd_at3 = powered_down;
                if (busy || n > 100) break;
                if (n == h) start_in = 1'b0;
                n++;
            end
            check(n == m_exp + 2, "R3 start time", n, m_exp + 2);
            check(g_hi, "R2 gated high at pulse end", g_hi, 1);
            check(g_lo && hold_seen, "R3 gated fall and hold_trig", {g_lo, hold_seen}, 3);
            if (pd_before) begin
                check(pd_at2 && !pd_at3, "R8 wake on pin rise", {pd_at2, pd_at3}, 2);
            end
            measure_busy(len);
            check(len == C, "R4 busy length", len, C);
            check(latch_strobe && data_out == val, "R5 latch at busy fall", data_out, val);
            check(powered_down, "R7 power down with pin low", powered_down, 1);
            conv_result = ~val;
            @(negedge clk);
            check(!latch_strobe, "R5 strobe one cycle", latch_strobe, 0);
            repeat (5) @(negedge clk);
            check(powered_down && data_out == val, "R10 data readable while down", data_out, val);
        end

        // Fast mode: pin rises during busy, stays high past the end.
        repeat (4) @(negedge clk);
        val = 8'hA5;
        conv_result = val;
        start_in = 1'b1;
        repeat (P + 4) @(negedge clk);
        start_in = 1'b0;
        n = 0;
        while (!busy && n < 100) begin
            @(negedge clk);
            n++;
        end
        len = 1;
        forever begin
            if (len == C - 4) start_in = 1'b1;
            @(negedge clk);
            if (!busy || len > 4 * C) break;
            len++;
        end
        check(len == C, "R4 busy length fast mode", len, C);
        check(!powered_down && data_out == val, "R6 stays powered with pin high", powered_down, 0);
        // R9: drop the pin now; no pulse from the ignored rise may delay the start.
        conv_result = 8'h3C;
        start_in = 1'b0;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (n == 2) check(!powered_down, "R6 powered after fast conversion", powered_down, 0);
            if (busy || n > 50) break;
        end
        check(n == 3, "R9 rise during busy ignored", n, 3);
        measure_busy(len);
        check(powered_down && data_out == 8'h3C, "R7 down after second conversion", data_out, 8'h3C);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule